// File: doc/BRIEF.md
# Pseudo-SRAM Page-Read Host Controller

This block sits between an on-chip requester and an external 2M x 16 pseudo-SRAM that has an asynchronous SRAM-style pin interface. A requester presents an address, write data, byte enables, a read/write flag and a burst flag with a word count on a valid/ready port. The controller turns each accepted request into a chip-enable bounded cycle on the memory pins. A write is one CE1-low window. A single read is one CE1-low window. A burst read keeps CE1 low, walks the three low address bits upward and returns one word per page step.

Every memory timing figure is a cycle-count parameter, rounded up from nanoseconds at the system clock. At 100 MHz the defaults give a 7-cycle random access and cycle time, a 2-cycle page step, a 4-cycle write pulse, a 1-cycle minimum chip-enable high time and a 400-cycle ceiling on any CE1-low window. The controller drives the 16-bit data bus only while a write is in progress. It hands the bus back well before it asserts output enable.

Top module: `psram_host_ctrl`

## Requirements
- R1: After reset the chip enable, output enable, write enable and both lane selects are high, the data bus is not driven, `req_ready` is high and `rd_valid` is low.
- R2: A write holds CE1 and WE low together for max(T_WP, T_CYC) cycles, with the bus driven and the address and data held throughout, and it stores the data at the request address.
- R3: `req_be` bit 0 enables the low byte (DQ7..0, LB low) and bit 1 enables the high byte (DQ15..8, UB low). `req_be` = 00 is taken as both lanes. A byte write leaves the other byte of the word unchanged. A read returns zero in any lane that is not enabled.
- R4: A single read holds CE1 and OE low and samples the bus max(T_ACC, T_CYC) cycles after the pins change. The result appears as a one-cycle `rd_valid` pulse in the cycle after sampling, so it comes max(T_ACC, T_CYC) cycles after the accepting edge.
- R5: A burst read (`req_burst` high) returns min(`req_len`+1, 8 - addr[2:0]) words. CE1 stays low for the whole burst and only addr[2:0] changes, rising by one per word. After the first word, each word is sampled T_PAGE cycles after its address step, and the words come back in ascending order. When `req_burst` is low, `req_len` is ignored and one word is returned.
- R6: Between two accesses CE1 stays high for at least T_CPH cycles, with OE and WE high.
- R7: The data bus is driven only while a write has CE1 low. It is never driven while OE is low, and it is released at least one cycle before OE falls.
- R8: CE1 is never low while OE and WE are both high.
- R9: No CE1-low window lasts T_CE_MAX cycles or longer.
- R10: `req_ready` is high only while no access or recovery is in progress. A request is taken on a clock edge with `req_valid` and `req_ready` both high.
- R11: WE and OE are never low together, and at least one lane select is low whenever CE1 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = page burst read |
| req_len | input | 3 | Burst words minus one |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables (bit 0 low byte, bit 1 high byte) |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | 21 | Memory address pins |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte select, active low |
| mem_ub_n | output | 1 | High byte select, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned by memory |

## Verification
The properties assume that the memory returns valid data no earlier than the access time measured from the pins, and that requests are presented only through the valid/ready handshake. They also assume that the fixed parameters keep a full 8-word burst well inside the CE1-low ceiling. The bench stands in for the memory with a model that returns a garbage pattern until the random-access and page ages counted at its pins have elapsed. Early sampling therefore shows up as wrong data. The bench raises `req_valid` only while `req_ready` is high, so each request goes through the handshake as intended. Its bursts start at different page offsets, so the word count is sometimes cut short at the page boundary.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int DQ_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_RD_RAND,
    ST_RD_PAGE,
    ST_GAP
  } psram_state_e;

  function automatic int cyc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // zero enables are taken as a full-word access
  function automatic logic [1:0] lanes_of(input logic [1:0] be);
    return (be == 2'b00) ? 2'b11 : be;
  endfunction

  // words a burst may return before the page boundary
  function automatic int page_words(input int lo, input int len, input int pw);
    int span;
    span = (1 << pw) - lo;
    return ((len + 1) < span) ? (len + 1) : span;
  endfunction

  function automatic logic [DQ_W-1:0] mask_lanes(input logic [DQ_W-1:0] d,
                                                 input logic [1:0] l);
    return {l[1] ? d[15:8] : 8'h00, l[0] ? d[7:0] : 8'h00};
  endfunction
endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/psram_rd_capture.sv
module psram_rd_capture
  import psram_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [1:0]      lanes,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= mask_lanes(dq_in, lanes);
    end
  end
endmodule

// File: rtl/psram_host_ctrl.sv
module psram_host_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int PAGE_W   = 3,
  parameter int T_ACC    = 7,
  parameter int T_CYC    = 7,
  parameter int T_PAGE   = 2,
  parameter int T_WP     = 4,
  parameter int T_CPH    = 1,
  parameter int T_CE_MAX = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [PAGE_W-1:0] req_len,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic [1:0]        req_be,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DQ_W-1:0]   mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DQ_W-1:0]   mem_dq_in
);
  localparam int RD_LEN = cyc_max(T_ACC, T_CYC);
  localparam int WR_LEN = cyc_max(T_WP, T_CYC);
  localparam int CW     = $clog2(cyc_max(cyc_max(RD_LEN, WR_LEN),
                                         cyc_max(T_PAGE, T_CPH)) + 1);
  localparam int NW     = PAGE_W + 1;

  psram_state_e      state;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   wdata_q;
  logic [1:0]        lanes_q;
  logic [NW-1:0]     left_q;
  logic              ce1_n_q, oe_n_q, we_n_q, lb_n_q, ub_n_q, dq_oe_q;

  // named events for the checker
  logic          accept;
  logic          word_capture;
  logic          tmr_zero;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic [1:0]    req_lanes;
  logic [NW-1:0] req_left;

  assign req_ready    = (state == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign word_capture = ((state == ST_RD_RAND) || (state == ST_RD_PAGE)) && tmr_zero;
  assign req_lanes    = lanes_of(req_be);
  assign req_left     = req_burst
                      ? NW'(page_words(int'(req_addr[PAGE_W-1:0]), int'(req_len), PAGE_W) - 1)
                      : '0;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        tmr_val  = req_write ? CW'(WR_LEN - 1) : CW'(RD_LEN - 1);
      end
      ST_WRITE: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = CW'(T_CPH - 1);
      end
      ST_RD_RAND, ST_RD_PAGE: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = (left_q != '0) ? CW'(T_PAGE - 1) : CW'(T_CPH - 1);
      end
      default: ;
    endcase
  end

  psram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      lanes_q <= 2'b11;
      left_q  <= '0;
      ce1_n_q <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      lb_n_q  <= 1'b1;
      ub_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          lanes_q <= req_lanes;
          lb_n_q  <= ~req_lanes[0];
          ub_n_q  <= ~req_lanes[1];
          ce1_n_q <= 1'b0;
          if (req_write) begin
            wdata_q <= req_wdata;
            we_n_q  <= 1'b0;
            dq_oe_q <= 1'b1;
            state   <= ST_WRITE;
          end else begin
            oe_n_q  <= 1'b0;
            left_q  <= req_left;
            state   <= ST_RD_RAND;
          end
        end
        ST_WRITE: if (tmr_zero) begin
          ce1_n_q <= 1'b1;
          we_n_q  <= 1'b1;
          dq_oe_q <= 1'b0;
          lb_n_q  <= 1'b1;
          ub_n_q  <= 1'b1;
          state   <= ST_GAP;
        end
        ST_RD_RAND, ST_RD_PAGE: if (tmr_zero) begin
          if (left_q != '0) begin
            addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};
            left_q <= left_q - 1'b1;
            state  <= ST_RD_PAGE;
          end else begin
            ce1_n_q <= 1'b1;
            oe_n_q  <= 1'b1;
            lb_n_q  <= 1'b1;
            ub_n_q  <= 1'b1;
            state   <= ST_GAP;
          end
        end
        ST_GAP: if (tmr_zero) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  psram_rd_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (word_capture),
    .lanes    (lanes_q),
    .dq_in    (mem_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign mem_addr   = addr_q;
  assign mem_ce1_n  = ce1_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_lb_n   = lb_n_q;
  assign mem_ub_n   = ub_n_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = dq_oe_q;
endmodule

// File: rtl/psram_host_ctrl_chk.sv
module psram_host_ctrl_chk #(
  parameter int ADDR_W   = 21,
  parameter int PAGE_W   = 3,
  parameter int T_CPH    = 1,
  parameter int T_CE_MAX = 400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              word_capture,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe
);
  localparam int CNT_W = $clog2(T_CE_MAX + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= CNT_W'(T_CPH);
      lo_cnt <= '0;
    end else begin
      hi_cnt <= mem_ce1_n ? ((hi_cnt == CNT_TOP) ? hi_cnt : hi_cnt + 1'b1) : '0;
      lo_cnt <= mem_ce1_n ? '0 : ((lo_cnt == CNT_TOP) ? lo_cnt : lo_cnt + 1'b1);
    end
  end

  AST_NO_OUT_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce1_n |-> !(mem_oe_n && mem_we_n)); // R8
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n)); // R7
  AST_BUS_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R7
  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce1_n && !mem_we_n)); // R7
  AST_CE_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce1_n) |-> (hi_cnt >= CNT_W'(T_CPH))); // R6
  AST_GAP_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce1_n |-> (mem_oe_n && mem_we_n)); // R6
  AST_CE_LOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce1_n |-> (lo_cnt < CNT_W'(T_CE_MAX))); // R9
  AST_PAGE_HIGH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |->
      (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W]))); // R5
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R11
  AST_LANE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce1_n |-> !(mem_lb_n && mem_ub_n)); // R11
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_dq_oe)); // R10
  AST_CAPTURE_READING: assert property (@(posedge clk) disable iff (!rst_n)
    word_capture |-> (!mem_ce1_n && !mem_oe_n)); // R4
  AST_VALID_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(word_capture)); // R4
endmodule

bind psram_host_ctrl psram_host_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .T_CPH(T_CPH), .T_CE_MAX(T_CE_MAX)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rd_valid     (rd_valid),
  .word_capture (word_capture),
  .mem_addr     (mem_addr),
  .mem_ce1_n    (mem_ce1_n),
  .mem_oe_n     (mem_oe_n),
  .mem_we_n     (mem_we_n),
  .mem_lb_n     (mem_lb_n),
  .mem_ub_n     (mem_ub_n),
  .mem_dq_oe    (mem_dq_oe)
);

// File: tb/sim_psram_host_ctrl.sv
module sim_psram_host_ctrl;
  localparam int T_ACC = 7, T_CYC = 7, T_PAGE = 2, T_WP = 4, T_CPH = 1, T_CE_MAX = 400;
  localparam int RD_LEN = (T_ACC > T_CYC) ? T_ACC : T_CYC;
  localparam int WR_LEN = (T_WP > T_CYC) ? T_WP : T_CYC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [2:0] req_len = '0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid, mem_ce1_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rd_data, mem_dq_out, mem_dq_in;
  logic [20:0] mem_addr;

  always #5 clk = ~clk;

  psram_host_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_len(req_len),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int errors = 0, checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input logic [20:0] a);
    return a[15:0] ^ {a[20:16], 11'h3A5};
  endfunction

  function automatic logic [15:0] keep_lanes(input logic [15:0] d, input logic [1:0] l);
    return {l[1] ? d[15:8] : 8'h00, l[0] ? d[7:0] : 8'h00};
  endfunction

  // ---------------- memory model at the pins ----------------
  logic [15:0] store [int];
  int acc_age = 0, pg_age = 0, hi_run = 100, lo_run = 0, lo_max = 0, wp_cnt = 0;
  logic prev_ce1_n = 1'b1;
  logic [20:0] prev_addr = '0, wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] wr_lanes = '0;

  always_comb begin
    logic [15:0] w;
    w = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : init_word(mem_addr);
    if (!mem_ce1_n && !mem_oe_n && acc_age >= T_ACC && pg_age >= T_PAGE)
      mem_dq_in = {mem_ub_n ? 8'hA5 : w[15:8], mem_lb_n ? 8'h5A : w[7:0]};
    else
      mem_dq_in = 16'hDEAD;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ce1_n) begin
        acc_age <= 0; pg_age <= 0; hi_run <= hi_run + 1; lo_run <= 0;
      end else begin
        if (prev_ce1_n) chk(hi_run >= T_CPH, "R6", "CE1 high run", hi_run, T_CPH);
        hi_run <= 0;
        lo_run <= lo_run + 1;
        if (lo_run + 1 > lo_max) lo_max <= lo_run + 1;
        acc_age <= (prev_ce1_n || mem_addr[20:3] != prev_addr[20:3]) ? 1 : acc_age + 1;
        pg_age  <= (prev_ce1_n || mem_addr[2:0] != prev_addr[2:0]) ? 1 : pg_age + 1;
      end
      if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R7", "bus driven with OE low", 1, 0);
      if (!mem_ce1_n && !mem_we_n) begin
        if (!mem_dq_oe) chk(1'b0, "R2", "bus not driven in write", 0, 1);
        wp_cnt   <= wp_cnt + 1;
        wr_addr  <= mem_addr;
        wr_data  <= mem_dq_out;
        wr_lanes <= {~mem_ub_n, ~mem_lb_n};
      end else if (wp_cnt > 0) begin
        logic [15:0] old;
        old = store.exists(int'(wr_addr)) ? store[int'(wr_addr)] : init_word(wr_addr);
        store[int'(wr_addr)] = {wr_lanes[1] ? wr_data[15:8] : old[15:8],
                                wr_lanes[0] ? wr_data[7:0]  : old[7:0]};
        chk(wp_cnt == WR_LEN, "R2", "write pulse cycles", wp_cnt, WR_LEN);
        wp_cnt <= 0;
      end
      prev_ce1_n <= mem_ce1_n;
      prev_addr  <= mem_addr;
    end
  end

  // ---------------- scoreboard ----------------
  logic [15:0] shadow [int];
  logic [15:0] exp_q [$];
  int rv_t [$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      rv_t.push_back(cyc);
      if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected read word", rd_data, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R4", "read data", rd_data, e);
      end
    end
  end

  function automatic logic [15:0] shadow_rd(input logic [20:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
  endfunction

  int acc_cyc = 0;

  task automatic send(input bit wr, input bit bu, input logic [2:0] len,
                      input logic [20:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_burst = bu; req_len = len;
    req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    acc_cyc = cyc;
    req_valid = 1'b0;
    chk(!req_ready, "R10", "ready while busy", req_ready, 0);
  endtask

  task automatic do_write(input logic [20:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [1:0] l;
    logic [15:0] o;
    l = (be == 2'b00) ? 2'b11 : be;
    o = shadow_rd(a);
    shadow[int'(a)] = {l[1] ? d[15:8] : o[15:8], l[0] ? d[7:0] : o[7:0]};
    send(1'b1, 1'b0, 3'd0, a, d, be);
  endtask

  task automatic do_read(input bit bu, input logic [2:0] len, input logic [20:0] a,
                         input logic [1:0] be);
    int n, span;
    logic [1:0] l;
    l = (be == 2'b00) ? 2'b11 : be;
    span = 8 - int'(a[2:0]);
    n = bu ? (((int'(len) + 1) < span) ? int'(len) + 1 : span) : 1;
    for (int i = 0; i < n; i++)
      exp_q.push_back(keep_lanes(shadow_rd({a[20:3], a[2:0] + 3'(i)}), l));
    send(1'b0, bu, len, a, 16'h0, be);
  endtask

  task automatic wait_idle();
    int k = 0;
    @(negedge clk);
    while (!(req_ready && mem_ce1_n && exp_q.size() == 0) && k < 500) begin
      @(negedge clk); k++;
    end
    chk(exp_q.size() == 0, "R5", "words outstanding", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce1_n === 1'b1, "R1", "ce1_n", mem_ce1_n, 1);
    chk(mem_oe_n === 1'b1 && mem_we_n === 1'b1, "R1", "oe_n/we_n", {mem_oe_n, mem_we_n}, 2'b11);
    chk(mem_lb_n === 1'b1 && mem_ub_n === 1'b1, "R1", "lanes", {mem_lb_n, mem_ub_n}, 2'b11);
    chk(mem_dq_oe === 1'b0, "R1", "dq_oe", mem_dq_oe, 0);
    chk(req_ready === 1'b1 && rd_valid === 1'b0, "R1", "ready/valid", {req_ready, rd_valid}, 2'b10);
    rst_n = 1'b1;

    // R2 / R4 word write then single read with latency
    do_write(21'h00010, 16'h1234, 2'b11);
    wait_idle();
    rv_t.delete();
    do_read(1'b0, 3'd0, 21'h00010, 2'b11);
    wait_idle();
    chk(rv_t.size() == 1 && rv_t[0] - acc_cyc == RD_LEN, "R4", "single read latency",
        rv_t.size() > 0 ? rv_t[0] - acc_cyc : -1, RD_LEN);

    // R3 byte lanes
    do_write(21'h00020, 16'hAAAA, 2'b00);
    do_write(21'h00020, 16'h11BB, 2'b01);
    do_write(21'h00020, 16'hCC22, 2'b10);
    do_read(1'b0, 3'd0, 21'h00020, 2'b11);
    do_read(1'b0, 3'd0, 21'h00020, 2'b01);
    do_read(1'b0, 3'd0, 21'h00020, 2'b10);
    wait_idle();

    // R5 full 8-word burst from an aligned address, page step timing
    for (int i = 0; i < 8; i++) do_write(21'h00040 + 21'(i), 16'h4000 + 16'(i * 17), 2'b11);
    wait_idle();
    rv_t.delete();
    do_read(1'b1, 3'd7, 21'h00040, 2'b11);
    wait_idle();
    chk(rv_t.size() == 8, "R5", "burst word count", rv_t.size(), 8);
    for (int i = 1; i < rv_t.size(); i++)
      chk(rv_t[i] - rv_t[i-1] == T_PAGE, "R5", "page step cycles", rv_t[i] - rv_t[i-1], T_PAGE);

    // R5 burst cut at page boundary, and burst flag low ignores length
    rv_t.delete();
    do_read(1'b1, 3'd7, 21'h00045, 2'b11);
    wait_idle();
    chk(rv_t.size() == 3, "R5", "truncated burst count", rv_t.size(), 3);
    rv_t.delete();
    do_read(1'b0, 3'd5, 21'h00041, 2'b11);
    wait_idle();
    chk(rv_t.size() == 1, "R5", "non-burst ignores len", rv_t.size(), 1);

    // top of address space, partial burst with one lane
    do_write(21'h1FFFFF, 16'h9F9F, 2'b11);
    do_read(1'b1, 3'd2, 21'h1FFFFC, 2'b10);
    wait_idle();

    // R6 / R7 mixed back-to-back traffic
    for (int n = 0; n < 60; n++) begin
      logic [20:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = {13'h0, lf[7:0]};
      if (lf[8]) do_write(a, lf ^ 16'h5EED, lf[10:9]);
      else do_read(lf[11], lf[14:12], a, lf[10:9]);
    end
    wait_idle();

    chk(lo_max < T_CE_MAX, "R9", "longest CE1 low run", lo_max, T_CE_MAX);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule